// File: doc/BRIEF.md
# Interrupt Status and Vector Unit

This unit collects event pulses from a serial-bus transfer engine into a sticky status register. It filters them through a per-event enable mask and drives one combined interrupt line. A two-bit DMA configuration lets the receive-ready and transmit-ready events act as DMA request lines instead of interrupts.

A simple host register port reads and writes the enable mask, the status register, the DMA configuration and a self-test register. It can also read a vector register. Reading the vector returns the 1-based index of the lowest pending enabled event and clears that event, so a handler can service events one read at a time.

The parameter `NEWER_REV` selects between two revisions of the unit. They differ in mask width, in whether the host may clear status bits, and in whether the self-test force is honoured.

Top module: `isu_top`

## Requirements
- R1: After reset the status, enable and DMA configuration registers read zero, and `irqOut`, `dmaRxReq` and `dmaTxReq` are low.
- R2: `irqOut` is high exactly when some status bit and its enable bit are both set.
- R3: `dmaRxReq` equals status bit 3 (receive ready) while DMA config bit 15 is set and is low otherwise. `dmaTxReq` equals status bit 4 (transmit ready) while DMA config bit 7 is set and is low otherwise.
- R4: A read of the vector register (select 2) returns the 1-based position of the lowest set bit of status AND enable, or 0 when none is set, and clears that one status bit.
- R5: On the newer revision, a write to the status register (select 1) clears each status bit whose written bit is one, but only among bits 0, 1, 2 and 5. Bits 3, 4 and all higher bits are unaffected.
- R6: A write to the DMA configuration (select 3) keeps only bits 15 and 7. A one in bit 15 clears enable bit 3, and a one in bit 7 clears enable bit 4.
- R7: The enable register (select 0) holds 6 bits on the newer revision and 5 bits on the older one. Higher bits read as zero.
- R8: Status readback shows the live `busBusy` input ORed into bit 12.
- R9: On the newer revision, a write to the self-test register (select 4) with bit 11 set forces status bits 0 to 5 to one. The older revision ignores it.
- R10: When an event pulse and a host clear hit the same status bit in the same cycle, the bit ends up set.
- R11: On the older revision, a status register write has no effect.
- R12: Read data is registered. `regRdData` shows the selected register, as it was before the edge, from the clock edge at which `regRdEn` was sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Host write strobe |
| regRdEn | input | 1 | Host read strobe |
| regAddr | input | 3 | Register select: 0 enable, 1 status, 2 vector, 3 DMA config, 4 self-test |
| regWrData | input | DATA_W | Host write data |
| regRdData | output | DATA_W | Registered host read data |
| evtSet | input | DATA_W | One-cycle event pulses, one per status bit |
| busBusy | input | 1 | Live bus-busy level shown in status bit 12 |
| irqOut | output | 1 | Combined interrupt |
| dmaRxReq | output | 1 | Receive DMA request |
| dmaTxReq | output | 1 | Transmit DMA request |

## Verification
The bench builds two copies side by side, both with `DATA_W` = 16. The instance `uut` uses `NEWER_REV` = 1 and `uutLegacy` uses `NEWER_REV` = 0, and they share the same stimulus.

This puts the revision-gated behaviour within reach of a single sequence: the 6-bit against 5-bit mask, the write-one-to-clear against read-only status, and the self-test force against no force. Each vector read is compared on both copies, because the two masks make each copy report and clear a different bit from the same status history.

// File: rtl/isu_pkg.sv
package isu_pkg;

  // Host register selects.
  typedef enum logic [2:0] {
    REG_ENABLE   = 3'd0,
    REG_STATUS   = 3'd1,
    REG_VECTOR   = 3'd2,
    REG_DMACFG   = 3'd3,
    REG_SELFTEST = 3'd4
  } regSel_e;

  // Strobes from control to datapath.
  typedef struct packed {
    logic    enWrite;
    logic    stWrite;
    logic    dmaWrite;
    logic    testWrite;
    logic    vecRead;
    logic    rdCapture;
    regSel_e rdSel;
  } hostStrobe_t;

endpackage

// File: rtl/isu_ctrl.sv
module isu_ctrl
  import isu_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic        regRdEn,
  input  logic [2:0]  regAddr,
  output hostStrobe_t strb
);

  regSel_e sel;
  assign sel = regSel_e'(regAddr);

  always_comb begin
    strb           = '0;
    strb.rdSel     = sel;
    strb.rdCapture = regRdEn;
    strb.vecRead   = regRdEn && (sel == REG_VECTOR);
    if (regWrEn) begin
      unique case (sel)
        REG_ENABLE:   strb.enWrite   = 1'b1;
        REG_STATUS:   strb.stWrite   = 1'b1;
        REG_DMACFG:   strb.dmaWrite  = 1'b1;
        REG_SELFTEST: strb.testWrite = 1'b1;
        default:      ;
      endcase
    end
  end

  // R5 / R6: a single host write touches at most one register.
  assert_one_write_R5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.enWrite, strb.stWrite, strb.dmaWrite, strb.testWrite}));

endmodule

// File: rtl/isu_datapath.sv
module isu_datapath
  import isu_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int NEWER_REV = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  hostStrobe_t       strb,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] evtSet,
  input  logic              busBusy,
  output logic [DATA_W-1:0] rdData,
  output logic              irqOut,
  output logic              dmaRxReq,
  output logic              dmaTxReq
);

  localparam int MASK_W    = (NEWER_REV != 0) ? 6 : 5;
  localparam int VEC_W     = $clog2(DATA_W + 1);
  localparam int RX_BIT    = 3;
  localparam int TX_BIT    = 4;
  localparam int BUSY_BIT  = 12;
  localparam int RXDMA_BIT = 15;
  localparam int TXDMA_BIT = 7;
  localparam int FORCE_BIT = 11;
  localparam logic [DATA_W-1:0] W1C_MASK   = DATA_W'(16'h0027);
  localparam logic [DATA_W-1:0] FORCE_MASK = DATA_W'(16'h003f);
  localparam bit    REV_NEW  = (NEWER_REV != 0);

  logic [DATA_W-1:0] statusQ, statusD;
  logic [MASK_W-1:0] enableQ, enableD;
  logic              rxDmaEnQ, txDmaEnQ;
  logic [DATA_W-1:0] pending, vecHit, clrBits, setBits, rdNext;
  logic [VEC_W-1:0]  vecIdx;

  assign pending = statusQ & {{(DATA_W-MASK_W){1'b0}}, enableQ};

  // Lowest pending enabled event wins.
  always_comb begin
    vecIdx = '0;
    vecHit = '0;
    for (int i = DATA_W - 1; i >= 0; i--) begin
      if (pending[i]) begin
        vecIdx    = VEC_W'(i + 1);
        vecHit    = '0;
        vecHit[i] = 1'b1;
      end
    end
  end

  always_comb begin
    clrBits = strb.vecRead ? vecHit : '0;
    if (REV_NEW && strb.stWrite) clrBits = clrBits | (wrData & W1C_MASK);
    setBits = evtSet;
    if (REV_NEW && strb.testWrite && wrData[FORCE_BIT]) setBits = setBits | FORCE_MASK;
    statusD = (statusQ & ~clrBits) | setBits;   // set beats clear
  end

  always_comb begin
    enableD = enableQ;
    if (strb.enWrite) enableD = wrData[MASK_W-1:0];
    if (strb.dmaWrite) begin
      if (wrData[RXDMA_BIT]) enableD[RX_BIT] = 1'b0;
      if (wrData[TXDMA_BIT]) enableD[TX_BIT] = 1'b0;
    end
  end

  always_comb begin
    rdNext = '0;
    unique case (strb.rdSel)
      REG_ENABLE: rdNext = {{(DATA_W-MASK_W){1'b0}}, enableQ};
      REG_STATUS: begin
        rdNext = statusQ;
        rdNext[BUSY_BIT] = statusQ[BUSY_BIT] | busBusy;
      end
      REG_VECTOR: rdNext = DATA_W'(vecIdx);
      REG_DMACFG: begin
        rdNext[RXDMA_BIT] = rxDmaEnQ;
        rdNext[TXDMA_BIT] = txDmaEnQ;
      end
      default: rdNext = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusQ  <= '0;
      enableQ  <= '0;
      rxDmaEnQ <= 1'b0;
      txDmaEnQ <= 1'b0;
      rdData   <= '0;
    end else begin
      statusQ <= statusD;
      enableQ <= enableD;
      if (strb.dmaWrite) begin
        rxDmaEnQ <= wrData[RXDMA_BIT];
        txDmaEnQ <= wrData[TXDMA_BIT];
      end
      if (strb.rdCapture) rdData <= rdNext;
    end
  end

  assign irqOut   = |pending;
  assign dmaRxReq = rxDmaEnQ & statusQ[RX_BIT];
  assign dmaTxReq = txDmaEnQ & statusQ[TX_BIT];

  // R10: every pulsed event is visible in status after the edge.
  assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((statusQ & $past(evtSet)) == $past(evtSet)));

  // R5: a host status write never drops the ready bits.
  assert_ready_kept_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.stWrite && !strb.vecRead) |=>
      ((statusQ[TX_BIT:RX_BIT] & $past(statusQ[TX_BIT:RX_BIT])) == $past(statusQ[TX_BIT:RX_BIT])));

  // R6: enabling receive DMA masks the receive-ready interrupt.
  assert_dma_masks_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.dmaWrite && wrData[RXDMA_BIT]) |=> !enableQ[RX_BIT]);

  // R4: a vector read with nothing arriving removes exactly one pending event.
  assert_vector_clear_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.vecRead && (pending != '0) && (evtSet == '0) && !strb.testWrite) |=>
      ($countones(pending) == $countones($past(pending)) - 1));

endmodule

// File: rtl/isu_top.sv
module isu_top
  import isu_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int NEWER_REV = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [2:0]        regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic [DATA_W-1:0] evtSet,
  input  logic              busBusy,
  output logic              irqOut,
  output logic              dmaRxReq,
  output logic              dmaTxReq
);

  hostStrobe_t strb;

  isu_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .regWrEn (regWrEn),
    .regRdEn (regRdEn),
    .regAddr (regAddr),
    .strb    (strb)
  );

  isu_datapath #(.DATA_W(DATA_W), .NEWER_REV(NEWER_REV)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .wrData   (regWrData),
    .evtSet   (evtSet),
    .busBusy  (busBusy),
    .rdData   (regRdData),
    .irqOut   (irqOut),
    .dmaRxReq (dmaRxReq),
    .dmaTxReq (dmaTxReq)
  );

endmodule

// File: tb/isu_top_test.sv
`timescale 1ns/1ps
module isu_top_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0, regRdEn = 1'b0, busBusy = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [15:0] regWrData = '0, evtSet = '0;
  logic [15:0] rdNew, rdOld;
  logic        irqNew, rxNew, txNew, irqOld, rxOld, txOld;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  isu_top #(.DATA_W(16), .NEWER_REV(1)) uut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(rdNew), .evtSet(evtSet), .busBusy(busBusy),
    .irqOut(irqNew), .dmaRxReq(rxNew), .dmaTxReq(txNew));

  isu_top #(.DATA_W(16), .NEWER_REV(0)) uutLegacy (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(rdOld), .evtSet(evtSet), .busBusy(busBusy),
    .irqOut(irqOld), .dmaRxReq(rxOld), .dmaTxReq(txOld));

  // Scoreboard queues
  logic [15:0] expNewQ[$];
  logic [15:0] expOldQ[$];
  bit          chkOldQ[$];
  string       tagQ[$];
  logic        issued = 1'b0;

  task automatic checkVal(input logic [15:0] act, input logic [15:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // R12: read data is sampled one cycle after the strobe.
  always @(posedge clk) issued <= regRdEn;

  always @(negedge clk) begin
    if (issued && expNewQ.size() > 0) begin
      string t;
      logic [15:0] en, eo;
      bit co;
      en = expNewQ.pop_front();
      eo = expOldQ.pop_front();
      co = chkOldQ.pop_front();
      t  = tagQ.pop_front();
      checkVal(rdNew, en, {t, " (new)"});
      if (co) checkVal(rdOld, eo, {t, " (legacy)"});
    end
  end

  task automatic hostRead(input logic [2:0] a, input logic [15:0] eNew,
                          input logic [15:0] eOld, input bit cOld, input string tag);
    @(negedge clk);
    expNewQ.push_back(eNew);
    expOldQ.push_back(eOld);
    chkOldQ.push_back(cOld);
    tagQ.push_back(tag);
    regAddr = a;
    regRdEn = 1'b1;
    @(negedge clk);
    regRdEn = 1'b0;
  endtask

  task automatic hostWrite(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic pulse(input logic [15:0] b);
    @(negedge clk);
    evtSet = b;
    @(negedge clk);
    evtSet = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1
    checkVal({13'd0, irqNew, rxNew, txNew}, 16'd0, "R1 outputs after reset");
    hostRead(3'd1, 16'h0000, 16'h0000, 1, "R1 R12 status after reset");
    hostRead(3'd0, 16'h0000, 16'h0000, 1, "R1 enable after reset");
    hostRead(3'd3, 16'h0000, 16'h0000, 1, "R1 dma config after reset");

    // R2: masked event keeps irq low, enabling raises it
    pulse(16'h0001);
    checkVal({15'd0, irqNew}, 16'd0, "R2 irq low while masked");
    hostWrite(3'd0, 16'hffff);
    @(negedge clk);
    checkVal({15'd0, irqNew}, 16'd1, "R2 irq high once enabled");
    hostRead(3'd0, 16'h003f, 16'h001f, 1, "R7 enable width");

    // R5 / R11
    hostWrite(3'd1, 16'h0001);
    @(negedge clk);
    checkVal({15'd0, irqNew}, 16'd0, "R5 irq low after w1c");
    checkVal({15'd0, irqOld}, 16'd1, "R11 legacy irq still high");
    pulse(16'h0018);
    hostWrite(3'd1, 16'hffff);
    hostRead(3'd1, 16'h0018, 16'h0019, 1, "R5 R11 ready bits kept");

    // R6 / R3
    hostWrite(3'd3, 16'hffff);
    hostRead(3'd3, 16'h8080, 16'h8080, 1, "R6 dma config bits");
    hostRead(3'd0, 16'h0027, 16'h0007, 1, "R6 ready enables masked");
    @(negedge clk);
    checkVal({14'd0, rxNew, txNew}, 16'h0003, "R3 both dma requests");
    checkVal({15'd0, irqNew}, 16'd0, "R2 irq low, ready bits masked");
    checkVal({15'd0, irqOld}, 16'd1, "R2 legacy irq from bit0");
    hostWrite(3'd3, 16'h0080);
    @(negedge clk);
    checkVal({14'd0, rxNew, txNew}, 16'h0001, "R3 rx dma gated off");

    // R4 vector reads
    pulse(16'h0024);
    hostRead(3'd2, 16'd3, 16'd1, 1, "R4 first vector");
    hostRead(3'd2, 16'd6, 16'd3, 1, "R4 second vector");
    hostRead(3'd2, 16'd0, 16'd0, 1, "R4 empty vector");
    hostRead(3'd1, 16'h0018, 16'h0038, 1, "R4 status after vectors");

    // R8 busy
    busBusy = 1'b1;
    hostRead(3'd1, 16'h1018, 16'h1038, 1, "R8 busy in readback");
    busBusy = 1'b0;

    // R10: set and clear together
    @(negedge clk);
    regAddr = 3'd1; regWrData = 16'h0001; regWrEn = 1'b1; evtSet = 16'h0001;
    @(negedge clk);
    regWrEn = 1'b0; evtSet = '0;
    hostRead(3'd1, 16'h0019, 16'h0039, 1, "R10 set wins");

    // R9 self-test force
    hostWrite(3'd4, 16'h0800);
    hostRead(3'd1, 16'h003f, 16'h0039, 1, "R9 self-test force");

    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule